// File: doc/BRIEF.md
# Coalesced Interrupt EOI Tracker

This block follows one special edge-triggered interrupt source and remembers which destinations have taken a delivery of it but have not yet sent back an end-of-interrupt (EOI). While any such EOI is outstanding, a fresh assertion of the source is reported as coalesced and is not forwarded. When the count of outstanding EOIs is zero, the assertion is forwarded for delivery.

For every delivery the block records three things: the bitmap of destinations reached, the vector that was used (kept separately for each destination), and a count of outstanding EOIs. An EOI from a destination retires that destination only when its pending bit is set and the EOI vector equals the vector stored for it. A clear command empties the record. A resync command rebuilds the record from the pending state reported by the destinations. If EOIs would drive the count below zero, the block performs the resync itself and pulses an error flag. Destination matching and message delivery happen outside this block.

Top module: `coal_eoi_tracker`

## Requirements
- R1: `coalesced` is 1 exactly when `pend_cnt` is nonzero; after reset `pend_cnt`, `pend_map`, `coalesced` and `err_pulse` are all 0.
- R2: When `src_req` is 1 and `pend_cnt` is nonzero, `src_coal` is 1 and `src_go` is 0 in the same cycle. When `src_req` is 1 and `pend_cnt` is 0, `src_go` is 1 and `src_coal` is 0.
- R3: A delivery (`dlv_valid`=1, `dlv_fail`=0) taken while `pend_cnt` is 0 sets `pend_map` to `dlv_map` and `pend_cnt` to the number of ones in `dlv_map` on the next cycle. It also stores `dlv_vec` as the vector of every destination in the map.
- R4: A failed delivery (`dlv_valid`=1, `dlv_fail`=1) taken while `pend_cnt` is 0 records `dlv_map` and the vector in the same way as R3, but loads `pend_cnt` with 0.
- R5: A delivery presented while `pend_cnt` is nonzero leaves `pend_map` and `pend_cnt` unchanged.
- R6: An EOI on lane i (`eoi_valid[i]`, with vector in `eoi_vec[8*i+7:8*i]`) retires destination i only if `pend_map[i]` is 1 and the EOI vector equals the stored vector. Retiring clears the bit and lowers `pend_cnt` by one. Several lanes may retire in the same cycle. `pend_cnt` never exceeds the number of ones in `pend_map`.
- R7: `clr_req` sets `pend_cnt` and `pend_map` to 0 on the next cycle. It takes priority over resync, delivery and EOIs.
- R8: `sync_req` sets `pend_map` to `sync_pend` and `pend_cnt` to the number of ones in `sync_pend`. It stores `sync_vec` for each destination in that map, and takes priority over delivery and EOIs.
- R9: If the EOIs retiring in one cycle outnumber `pend_cnt`, the block performs the R8 resync from that cycle's `sync_pend`/`sync_vec` instead. `err_pulse` is then 1 for exactly the following cycle.
- R10: In a cycle where a delivery is taken, the EOI inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 1 | New assertion of the tracked source |
| src_go | output | 1 | Assertion may be delivered |
| src_coal | output | 1 | Assertion is coalesced and dropped |
| dlv_valid | input | 1 | Delivery result presented |
| dlv_fail | input | 1 | Delivery attempt failed |
| dlv_map | input | NUM_DEST | Destinations reached |
| dlv_vec | input | VEC_W | Vector used for the delivery |
| eoi_valid | input | NUM_DEST | Per-destination EOI strobe |
| eoi_vec | input | NUM_DEST*VEC_W | Per-destination EOI vector, lane i at bits [VEC_W*i +: VEC_W] |
| sync_req | input | 1 | Resync command |
| sync_pend | input | NUM_DEST | Current pending-EOI state of each destination |
| sync_vec | input | VEC_W | Vector of the source at resync time |
| clr_req | input | 1 | Clear command |
| coalesced | output | 1 | Outstanding EOIs exist |
| err_pulse | output | 1 | One-cycle flag after an underflow resync |
| pend_map | output | NUM_DEST | Destinations still owing an EOI |
| pend_cnt | output | CNT_W | Outstanding EOI count |

## Verification
The bench builds the block with its defaults: eight destinations and 8-bit vectors. With eight lanes it can retire three EOIs in one cycle, give one lane a wrong vector, and send an EOI to a lane that is not pending. It can also drive an underflow by following a failed delivery to two destinations with an EOI. The 8-bit vectors let distinct values such as 0x41 and 0x42 separate a match from a near miss.

// File: rtl/coal_trk_pkg.sv
package coal_trk_pkg;
    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_CLEAR,
        ACT_SYNC,
        ACT_LOAD,
        ACT_RETIRE,
        ACT_UNDERFLOW
    } trk_act_e;
endpackage

// File: rtl/coal_popcount.sv
module coal_popcount #(
    parameter int W  = 8,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  bits_in,
    output logic [CW-1:0] ones
);
    always_comb begin
        ones = '0;
        for (int i = 0; i < W; i++) begin
            ones = ones + CW'(bits_in[i]);
        end
    end
endmodule

// File: rtl/coal_eoi_match.sv
module coal_eoi_match #(
    parameter int NUM_DEST = 8,
    parameter int VEC_W    = 8
) (
    input  logic [NUM_DEST-1:0]       eoi_valid,
    input  logic [NUM_DEST*VEC_W-1:0] eoi_vec,
    input  logic [NUM_DEST-1:0]       pend,
    input  logic [NUM_DEST*VEC_W-1:0] stored_vec,
    output logic [NUM_DEST-1:0]       hit
);
    for (genvar g = 0; g < NUM_DEST; g++) begin : g_lane
        assign hit[g] = eoi_valid[g] && pend[g] &&
                        (eoi_vec[g*VEC_W +: VEC_W] == stored_vec[g*VEC_W +: VEC_W]);
    end
endmodule

// File: rtl/coal_eoi_tracker.sv
module coal_eoi_tracker
    import coal_trk_pkg::*;
#(
    parameter int NUM_DEST = 8,
    parameter int VEC_W    = 8,
    localparam int CNT_W   = $clog2(NUM_DEST + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      src_req,
    output logic                      src_go,
    output logic                      src_coal,
    input  logic                      dlv_valid,
    input  logic                      dlv_fail,
    input  logic [NUM_DEST-1:0]       dlv_map,
    input  logic [VEC_W-1:0]          dlv_vec,
    input  logic [NUM_DEST-1:0]       eoi_valid,
    input  logic [NUM_DEST*VEC_W-1:0] eoi_vec,
    input  logic                      sync_req,
    input  logic [NUM_DEST-1:0]       sync_pend,
    input  logic [VEC_W-1:0]          sync_vec,
    input  logic                      clr_req,
    output logic                      coalesced,
    output logic                      err_pulse,
    output logic [NUM_DEST-1:0]       pend_map,
    output logic [CNT_W-1:0]          pend_cnt
);
    typedef struct packed {
        logic [NUM_DEST-1:0]       map;
        logic [NUM_DEST*VEC_W-1:0] vec;
        logic [CNT_W-1:0]          cnt;
        logic                      err;
    } trk_st_t;

    trk_st_t st_d, st_q;
    trk_act_e act;

    logic [NUM_DEST-1:0] hit;
    logic [CNT_W-1:0]    dlv_ones, sync_ones, hit_ones;

    coal_eoi_match #(.NUM_DEST(NUM_DEST), .VEC_W(VEC_W)) u_match (
        .eoi_valid  (eoi_valid),
        .eoi_vec    (eoi_vec),
        .pend       (st_q.map),
        .stored_vec (st_q.vec),
        .hit        (hit)
    );

    coal_popcount #(.W(NUM_DEST), .CW(CNT_W)) u_pc_dlv  (.bits_in(dlv_map),   .ones(dlv_ones));
    coal_popcount #(.W(NUM_DEST), .CW(CNT_W)) u_pc_sync (.bits_in(sync_pend), .ones(sync_ones));
    coal_popcount #(.W(NUM_DEST), .CW(CNT_W)) u_pc_hit  (.bits_in(hit),       .ones(hit_ones));

    always_comb begin
        if (clr_req)                           act = ACT_CLEAR;
        else if (sync_req)                     act = ACT_SYNC;
        else if (dlv_valid && st_q.cnt == '0)  act = ACT_LOAD;
        else if (|hit && hit_ones > st_q.cnt)  act = ACT_UNDERFLOW;
        else if (|hit)                         act = ACT_RETIRE;
        else                                   act = ACT_HOLD;
    end

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        case (act)
            ACT_CLEAR: begin
                st_d.map = '0;
                st_d.cnt = '0;
            end
            ACT_SYNC, ACT_UNDERFLOW: begin
                st_d.map = sync_pend;
                st_d.cnt = sync_ones;
                for (int i = 0; i < NUM_DEST; i++) begin
                    if (sync_pend[i]) st_d.vec[i*VEC_W +: VEC_W] = sync_vec;
                end
                st_d.err = (act == ACT_UNDERFLOW);
            end
            ACT_LOAD: begin
                st_d.map = dlv_map;
                st_d.cnt = dlv_fail ? '0 : dlv_ones;
                for (int i = 0; i < NUM_DEST; i++) begin
                    if (dlv_map[i]) st_d.vec[i*VEC_W +: VEC_W] = dlv_vec;
                end
            end
            ACT_RETIRE: begin
                st_d.map = st_q.map & ~hit;
                st_d.cnt = st_q.cnt - hit_ones;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign coalesced = (st_q.cnt != '0);
    assign src_coal  = src_req && coalesced;
    assign src_go    = src_req && !coalesced;
    assign err_pulse = st_q.err;
    assign pend_map  = st_q.map;
    assign pend_cnt  = st_q.cnt;

    // R2
    src_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req && pend_cnt != '0) |-> (src_coal && !src_go));
    // R3
    dlv_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && !dlv_fail && !clr_req && !sync_req && pend_cnt == '0)
        |=> (pend_map == $past(dlv_map) && int'(pend_cnt) == $countones($past(dlv_map))));
    // R5
    dlv_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && pend_cnt != '0 && !clr_req && !sync_req && eoi_valid == '0)
        |=> ($stable(pend_map) && $stable(pend_cnt)));
    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pend_cnt) <= $countones(pend_map));
    // R7
    clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> (pend_cnt == '0 && pend_map == '0));
    // R9
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> !err_pulse);
endmodule

// File: tb/sim_coal_eoi_tracker.sv
`timescale 1ns/1ps
module sim_coal_eoi_tracker;
    localparam int N  = 8;
    localparam int VW = 8;
    localparam int CW = $clog2(N + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic src_req, dlv_valid, dlv_fail, sync_req, clr_req;
    logic [N-1:0] dlv_map, eoi_valid, sync_pend, pend_map;
    logic [VW-1:0] dlv_vec, sync_vec;
    logic [N*VW-1:0] eoi_vec;
    logic src_go, src_coal, coalesced, err_pulse;
    logic [CW-1:0] pend_cnt;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    coal_eoi_tracker #(.NUM_DEST(N), .VEC_W(VW)) u0 (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_go(src_go), .src_coal(src_coal),
        .dlv_valid(dlv_valid), .dlv_fail(dlv_fail), .dlv_map(dlv_map), .dlv_vec(dlv_vec),
        .eoi_valid(eoi_valid), .eoi_vec(eoi_vec), .sync_req(sync_req), .sync_pend(sync_pend),
        .sync_vec(sync_vec), .clr_req(clr_req), .coalesced(coalesced), .err_pulse(err_pulse),
        .pend_map(pend_map), .pend_cnt(pend_cnt)
    );

    task automatic idle_inputs();
        src_req = 0; dlv_valid = 0; dlv_fail = 0; dlv_map = '0; dlv_vec = '0;
        eoi_valid = '0; eoi_vec = '0; sync_req = 0; sync_pend = '0; sync_vec = '0; clr_req = 0;
    endtask

    task automatic tick();
        @(posedge clk); #1;
        idle_inputs();
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic state_is(string tag, logic [N-1:0] m, int c);
        chk({tag, " map"}, 32'(pend_map), 32'(m));
        chk({tag, " cnt"}, 32'(pend_cnt), 32'(c));
        chk({tag, " coalesced R1"}, 32'(coalesced), 32'(c != 0));
    endtask

    task automatic eoi_all(logic [N-1:0] lanes, logic [VW-1:0] v);
        eoi_valid = lanes;
        for (int i = 0; i < N; i++) eoi_vec[i*VW +: VW] = v;
    endtask

    task automatic t_reset();
        state_is("R1 reset", '0, 0);
        chk("R1 reset err", 32'(err_pulse), 0);
        src_req = 1; #1;
        chk("R2 go when idle", 32'(src_go), 1);
        chk("R2 no coal when idle", 32'(src_coal), 0);
        src_req = 0;
    endtask

    task automatic t_deliver_and_retire();
        dlv_valid = 1; dlv_map = 8'h05; dlv_vec = 8'h41; tick();
        state_is("R3 load", 8'h05, 2);
        src_req = 1; #1;
        chk("R2 coal while pending", 32'(src_coal), 1);
        chk("R2 no go while pending", 32'(src_go), 0);
        src_req = 0;
        dlv_valid = 1; dlv_map = 8'hF0; dlv_vec = 8'h99; tick();
        state_is("R5 blocked delivery", 8'h05, 2);
        eoi_all(8'h01, 8'h42); tick();
        state_is("R6 wrong vector", 8'h05, 2);
        eoi_all(8'h02, 8'h41); tick();
        state_is("R6 not pending lane", 8'h05, 2);
        eoi_all(8'h01, 8'h41); tick();
        state_is("R6 retire one", 8'h04, 1);
        eoi_all(8'h04, 8'h41); tick();
        state_is("R6 retire last", 8'h00, 0);
    endtask

    task automatic t_multi_retire();
        dlv_valid = 1; dlv_map = 8'hF0; dlv_vec = 8'h22; tick();
        state_is("R3 load four", 8'hF0, 4);
        eoi_all(8'h70, 8'h22); tick();
        state_is("R6 three at once", 8'h80, 1);
        clr_req = 1; sync_req = 1; sync_pend = 8'hFF; tick();
        state_is("R7 clear wins", 8'h00, 0);
    endtask

    task automatic t_load_ignores_eoi();
        dlv_valid = 1; dlv_map = 8'h01; dlv_vec = 8'h10; tick();
        eoi_all(8'h01, 8'h10); tick();
        state_is("R6 setup", 8'h00, 0);
        dlv_valid = 1; dlv_map = 8'h03; dlv_vec = 8'h10; eoi_all(8'h01, 8'h10); tick();
        state_is("R10 eoi ignored on load", 8'h03, 2);
        clr_req = 1; tick();
        state_is("R7 clear", 8'h00, 0);
    endtask

    task automatic t_fail_underflow();
        dlv_valid = 1; dlv_fail = 1; dlv_map = 8'h03; dlv_vec = 8'h33; tick();
        state_is("R4 failed load", 8'h03, 0);
        eoi_all(8'h01, 8'h33); sync_pend = 8'h02; sync_vec = 8'h44; tick();
        state_is("R9 underflow resync", 8'h02, 1);
        chk("R9 err set", 32'(err_pulse), 1);
        eoi_all(8'h02, 8'h44); tick();
        chk("R9 err one cycle", 32'(err_pulse), 0);
        state_is("R8 resync vector used", 8'h00, 0);
    endtask

    task automatic t_resync();
        sync_req = 1; sync_pend = 8'h90; sync_vec = 8'h55;
        dlv_valid = 1; dlv_map = 8'h01; dlv_vec = 8'h66; tick();
        state_is("R8 resync", 8'h90, 2);
        chk("R8 no err", 32'(err_pulse), 0);
        eoi_all(8'h80, 8'h55); tick();
        state_is("R8 retire after resync", 8'h10, 1);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        repeat (2) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_deliver_and_retire();
        t_multi_retire();
        t_load_ignores_eoi();
        t_fail_underflow();
        t_resync();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule